// File: doc/BRIEF.md
# Wavefront Launch ID Initializer

This block prepares the per-lane identity of one wavefront when that wavefront of a workgroup is launched. It is given the three workgroup dimensions, the index of the wave inside its group, a flat workgroup number and the grid's workgroup counts along x and y. From these it streams one record per lane, one lane per cycle. Each record carries the lane's 3D work-item id, its flattened id and whether the lane is live. While streaming, it also builds the initial execution mask. It also produces the 3D workgroup id and the number of waves the group needs. That wave count is compared against the number of free wave slots to decide whether the group fits.

A launch begins with a one-cycle `start` while the block is idle. Two sequential restoring dividers work in two stages. The first stage splits the wave's first global lane index by the x size and, in parallel, the flat group number by the grid x count. The second stage splits the quotients by the y size and the grid y count. After that, a mixed-radix counter steps x, then y, then z for each following lane, so no divider is needed per lane. The lane records leave on a valid/ready stream. When `lane_ready` is low, the current record is held unchanged and nothing is lost or repeated. `done` pulses once after the last record is accepted. The mask, group id, wave count and fit flag then stay unchanged until the next accepted `start`.

The wavefront width `LANES` must be a power of two and at least 2. The dimensions and grid counts must be non-zero.

Top module: `wave_id_init`

## Requirements
- R1: After reset, and after a reset applied in the middle of a launch, `busy`, `lane_valid` and `done` are 0 and `exec_mask`, `waves_needed` and `fits` are all zero.
- R2: `start` is taken only while `busy` is 0; `busy` is 1 from the cycle after an accepted `start` until `done`. A `start` raised while busy, even with different inputs, leaves that launch's results unchanged.
- R3: Exactly `LANES` records leave per launch, with `lane_idx` running 0,1,…,LANES-1 in order. While `lane_valid` is 1 and `lane_ready` is 0, the record does not change.
- R4: With g = wave_idx × LANES + lane_idx, the record's coordinates are `lane_x` = g mod size_x, `lane_y` = (g / size_x) mod size_y and `lane_z` = g / (size_x × size_y), using integer division.
- R5: `lane_flat` = lane_z × size_x × size_y + lane_y × size_x + lane_x, so it rises by exactly one from each lane to the next.
- R6: `lane_active` is 1 exactly when g < size_x × size_y × size_z. After `done`, bit k of `exec_mask` (bit 0 = lane 0) equals lane k's `lane_active`.
- R7: The group id splits `grp_num` the same way: `grp_x` = grp_num mod grid_x, `grp_y` = (grp_num / grid_x) mod grid_y, `grp_z` = grp_num / (grid_x × grid_y).
- R8: `waves_needed` = ceil(size_x × size_y × size_z / LANES). `fits` is 1 exactly when `waves_needed` ≤ `free_slots`, with both taken at the accepted `start`.
- R9: `done` is 1 for exactly one cycle, the cycle after the last record's handshake, with `busy` already 0. `exec_mask`, `grp_x/y/z`, `waves_needed` and `fits` then hold until the next accepted `start`, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a launch (taken only when idle) |
| size_x | input | DIM_W | Workgroup size along x |
| size_y | input | DIM_W | Workgroup size along y |
| size_z | input | DIM_W | Workgroup size along z |
| wave_idx | input | WAVE_W | Index of this wave inside its workgroup |
| grp_num | input | GRP_W | Flat workgroup number |
| grid_x | input | GRP_W | Workgroup count of the grid along x |
| grid_y | input | GRP_W | Workgroup count of the grid along y |
| free_slots | input | WAVE_W | Wave slots currently free |
| busy | output | 1 | Launch in progress |
| lane_valid | output | 1 | Lane record available |
| lane_ready | input | 1 | Consumer accepts the lane record |
| lane_idx | output | log2(LANES) | Lane number within the wave |
| lane_x | output | DIM_W | Work-item x id |
| lane_y | output | DIM_W | Work-item y id |
| lane_z | output | 3·DIM_W | Work-item z id |
| lane_flat | output | 3·DIM_W | Flattened work-item id |
| lane_active | output | 1 | Lane lies inside the workgroup |
| done | output | 1 | One-cycle pulse after the last lane |
| exec_mask | output | LANES | Initial execution mask, bit k = lane k |
| grp_x | output | GRP_W | Workgroup x id |
| grp_y | output | GRP_W | Workgroup y id |
| grp_z | output | GRP_W | Workgroup z id |
| waves_needed | output | 3·DIM_W | Waves the workgroup requires |
| fits | output | 1 | Required waves do not exceed free slots |

## Verification
The embedded properties rely on the following:
- `size_x`, `size_y`, `grid_x` and `grid_y` are non-zero when `start` is accepted, so every divisor is non-zero and each remainder is smaller than its divisor.
- `wave_idx × LANES + LANES − 1` fits in 3·DIM_W bits, so the flat id can step by one without wrapping.
- Nothing is assumed of `lane_ready`.

The stimulus table uses only sizes and grid counts of 1 or more, with wave indices small enough to meet the width limit. It drives `lane_ready` with several gapped patterns and one long stall. It raises a stray `start` only while a launch is under way.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DIV_A = 2'd1,
    ST_DIV_B = 2'd2,
    ST_EMIT  = 2'd3
  } wl_state_e;
endpackage

// File: rtl/wl_seqdiv.sv
module wl_seqdiv #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    trial, diff;
  logic          ge;

  // one restoring step: shift in the next dividend bit, subtract if possible
  assign trial = {rem_q, quo_q[W-1]};
  assign ge    = trial >= {1'b0, dvs_q};
  assign diff  = trial - {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo_q <= dividend;
        dvs_q <= divisor;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff[W-1:0] : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
  assign rem  = rem_q;

  // R4
  rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < dvs_q));

  // R4
  sub_no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ge) |-> !diff[W]);

  // R2
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !go);
endmodule

// File: rtl/wl_coord_step.sv
module wl_coord_step #(
  parameter int DIM_W  = 8,
  parameter int FLAT_W = 24
) (
  input  logic [DIM_W-1:0]  x,
  input  logic [DIM_W-1:0]  y,
  input  logic [FLAT_W-1:0] z,
  input  logic [DIM_W-1:0]  sx,
  input  logic [DIM_W-1:0]  sy,
  output logic [DIM_W-1:0]  nx,
  output logic [DIM_W-1:0]  ny,
  output logic [FLAT_W-1:0] nz
);
  logic wrap_x, wrap_y;

  assign wrap_x = (x == sx - 1'b1);
  assign wrap_y = (y == sy - 1'b1);

  always_comb begin
    nx = wrap_x ? '0 : x + 1'b1;
    ny = y;
    nz = z;
    if (wrap_x) begin
      ny = wrap_y ? '0 : y + 1'b1;
      if (wrap_y) nz = z + 1'b1;
    end
  end
endmodule

// File: rtl/wl_wave_count.sv
module wl_wave_count #(
  parameter int LANES  = 8,
  parameter int FLAT_W = 24,
  parameter int WAVE_W = 8
) (
  input  logic [FLAT_W-1:0] total,
  input  logic [WAVE_W-1:0] free_slots,
  output logic [FLAT_W-1:0] waves,
  output logic              fits
);
  localparam int LOG_L = $clog2(LANES);

  logic [FLAT_W:0] biased;

  assign biased = {1'b0, total} + (FLAT_W + 1)'(LANES - 1);
  assign waves  = FLAT_W'(biased >> LOG_L);
  assign fits   = waves <= FLAT_W'(free_slots);
endmodule

// File: rtl/wave_id_init.sv
module wave_id_init #(
  parameter int LANES  = 8,
  parameter int DIM_W  = 8,
  parameter int WAVE_W = 8,
  parameter int GRP_W  = 16,
  localparam int LOG_L  = $clog2(LANES),
  localparam int FLAT_W = 3 * DIM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  size_x,
  input  logic [DIM_W-1:0]  size_y,
  input  logic [DIM_W-1:0]  size_z,
  input  logic [WAVE_W-1:0] wave_idx,
  input  logic [GRP_W-1:0]  grp_num,
  input  logic [GRP_W-1:0]  grid_x,
  input  logic [GRP_W-1:0]  grid_y,
  input  logic [WAVE_W-1:0] free_slots,
  output logic              busy,
  output logic              lane_valid,
  input  logic              lane_ready,
  output logic [LOG_L-1:0]  lane_idx,
  output logic [DIM_W-1:0]  lane_x,
  output logic [DIM_W-1:0]  lane_y,
  output logic [FLAT_W-1:0] lane_z,
  output logic [FLAT_W-1:0] lane_flat,
  output logic              lane_active,
  output logic              done,
  output logic [LANES-1:0]  exec_mask,
  output logic [GRP_W-1:0]  grp_x,
  output logic [GRP_W-1:0]  grp_y,
  output logic [GRP_W-1:0]  grp_z,
  output logic [FLAT_W-1:0] waves_needed,
  output logic              fits
);
  import wl_pkg::*;

  localparam int DV_W = (FLAT_W > GRP_W) ? FLAT_W : GRP_W;
  localparam logic [LOG_L-1:0] LAST_LANE = LOG_L'(LANES - 1);

  wl_state_e st_q;

  logic [DIM_W-1:0]  sx_q, sy_q, x_q, y_q, nx, ny;
  logic [FLAT_W-1:0] sxy_q, total_q, g_q, z_q, nz;
  logic [GRP_W-1:0]  cy_q, gx_q, gy_q, gz_q;
  logic [LOG_L-1:0]  k_q;
  logic [LANES-1:0]  mask_q;
  logic [FLAT_W-1:0] waves_q, wc_waves, total_in, g0;
  logic              fits_q, wc_fits, done_q;
  logic              accept, hs, div_go;

  logic [DV_W-1:0] ld_dvd, ld_dvs, ld_quo, ld_rem;
  logic [DV_W-1:0] gd_dvd, gd_dvs, gd_quo, gd_rem;
  logic            ld_done, gd_done;

  assign accept   = start && (st_q == ST_IDLE);
  assign hs       = lane_valid && lane_ready;
  assign total_in = FLAT_W'(size_x) * FLAT_W'(size_y) * FLAT_W'(size_z);
  assign g0       = FLAT_W'({wave_idx, {LOG_L{1'b0}}});
  assign div_go   = accept || ((st_q == ST_DIV_A) && ld_done);

  // stage A divides the launch inputs, stage B divides the stage-A quotients
  always_comb begin
    if (st_q == ST_IDLE) begin
      ld_dvd = DV_W'(g0);
      ld_dvs = DV_W'(size_x);
      gd_dvd = DV_W'(grp_num);
      gd_dvs = DV_W'(grid_x);
    end else begin
      ld_dvd = ld_quo;
      ld_dvs = DV_W'(sy_q);
      gd_dvd = gd_quo;
      gd_dvs = DV_W'(cy_q);
    end
  end

  wl_seqdiv #(.W(DV_W)) u_lane_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .dividend(ld_dvd), .divisor(ld_dvs),
    .done(ld_done), .quo(ld_quo), .rem(ld_rem)
  );

  wl_seqdiv #(.W(DV_W)) u_grp_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .dividend(gd_dvd), .divisor(gd_dvs),
    .done(gd_done), .quo(gd_quo), .rem(gd_rem)
  );

  wl_coord_step #(.DIM_W(DIM_W), .FLAT_W(FLAT_W)) u_step (
    .x(x_q), .y(y_q), .z(z_q), .sx(sx_q), .sy(sy_q),
    .nx(nx), .ny(ny), .nz(nz)
  );

  wl_wave_count #(.LANES(LANES), .FLAT_W(FLAT_W), .WAVE_W(WAVE_W)) u_wc (
    .total(total_in), .free_slots(free_slots),
    .waves(wc_waves), .fits(wc_fits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sx_q    <= '0;
      sy_q    <= '0;
      sxy_q   <= '0;
      total_q <= '0;
      cy_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
      z_q     <= '0;
      g_q     <= '0;
      k_q     <= '0;
      gx_q    <= '0;
      gy_q    <= '0;
      gz_q    <= '0;
      mask_q  <= '0;
      waves_q <= '0;
      fits_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            sx_q    <= size_x;
            sy_q    <= size_y;
            sxy_q   <= FLAT_W'(size_x) * FLAT_W'(size_y);
            total_q <= total_in;
            cy_q    <= grid_y;
            g_q     <= g0;
            mask_q  <= '0;
            waves_q <= wc_waves;
            fits_q  <= wc_fits;
            st_q    <= ST_DIV_A;
          end
        end
        ST_DIV_A: begin
          if (ld_done) begin
            x_q  <= ld_rem[DIM_W-1:0];
            gx_q <= gd_rem[GRP_W-1:0];
            st_q <= ST_DIV_B;
          end
        end
        ST_DIV_B: begin
          if (ld_done) begin
            y_q  <= ld_rem[DIM_W-1:0];
            z_q  <= ld_quo[FLAT_W-1:0];
            gy_q <= gd_rem[GRP_W-1:0];
            gz_q <= gd_quo[GRP_W-1:0];
            k_q  <= '0;
            st_q <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (hs) begin
            mask_q[k_q] <= lane_active;
            if (k_q == LAST_LANE) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              k_q <= k_q + 1'b1;
              g_q <= g_q + 1'b1;
              x_q <= nx;
              y_q <= ny;
              z_q <= nz;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (st_q != ST_IDLE);
  assign lane_valid   = (st_q == ST_EMIT);
  assign lane_idx     = k_q;
  assign lane_x       = x_q;
  assign lane_y       = y_q;
  assign lane_z       = z_q;
  assign lane_flat    = z_q * sxy_q + FLAT_W'(y_q) * FLAT_W'(sx_q) + FLAT_W'(x_q);
  assign lane_active  = g_q < total_q;
  assign done         = done_q;
  assign exec_mask    = mask_q;
  assign grp_x        = gx_q;
  assign grp_y        = gy_q;
  assign grp_z        = gz_q;
  assign waves_needed = waves_q;
  assign fits         = fits_q;

  // R7
  div_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done == gd_done);

  // R4
  rem_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> (((ld_rem >> DIM_W) == '0) && ((gd_rem >> GRP_W) == '0)));

  // R4
  coord_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid |-> ((lane_x < sx_q) && (lane_y < sy_q)));

  // R3
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid && !lane_ready) |=>
      (lane_valid && $stable(lane_idx) && $stable(lane_flat) && $stable(lane_active)));

  // R5
  flat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && (lane_idx != LAST_LANE)) |=> (lane_flat == $past(lane_flat) + 1'b1));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=>
      ($stable(exec_mask) && $stable(grp_x) && $stable(grp_y) && $stable(grp_z)
       && $stable(waves_needed) && $stable(fits)));
endmodule

// File: tb/wave_id_init_tb_top.sv
module wave_id_init_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 8;
  localparam int DIM_W  = 8;
  localparam int WAVE_W = 8;
  localparam int GRP_W  = 16;
  localparam int LOG_L  = 3;
  localparam int FLAT_W = 24;
  localparam int NVEC   = 8;

  // columns: sx, sy, sz, wave, grp, grid_x, grid_y, free
  localparam int VEC [NVEC][8] = '{
    '{4, 2, 1, 0, 5, 3, 2, 2},
    '{3, 3, 2, 1, 7, 4, 4, 3},
    '{3, 3, 2, 2, 0, 1, 1, 3},
    '{5, 1, 1, 0, 9, 2, 5, 1},
    '{1, 1, 1, 0, 3, 1, 1, 0},
    '{2, 3, 4, 2, 11, 2, 3, 3},
    '{7, 5, 3, 9, 40, 6, 5, 13},
    '{255, 255, 255, 255, 65535, 300, 7, 255}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DIM_W-1:0]  size_x = '0, size_y = '0, size_z = '0;
  logic [WAVE_W-1:0] wave_idx = '0, free_slots = '0;
  logic [GRP_W-1:0]  grp_num = '0, grid_x = '0, grid_y = '0;
  logic lane_ready = 1'b0;
  logic busy, lane_valid, lane_active, done, fits;
  logic [LOG_L-1:0]  lane_idx;
  logic [DIM_W-1:0]  lane_x, lane_y;
  logic [FLAT_W-1:0] lane_z, lane_flat, waves_needed;
  logic [LANES-1:0]  exec_mask;
  logic [GRP_W-1:0]  grp_x, grp_y, grp_z;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wave_id_init #(.LANES(LANES), .DIM_W(DIM_W), .WAVE_W(WAVE_W), .GRP_W(GRP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .size_x(size_x), .size_y(size_y), .size_z(size_z),
    .wave_idx(wave_idx), .grp_num(grp_num), .grid_x(grid_x), .grid_y(grid_y),
    .free_slots(free_slots), .busy(busy), .lane_valid(lane_valid),
    .lane_ready(lane_ready), .lane_idx(lane_idx), .lane_x(lane_x),
    .lane_y(lane_y), .lane_z(lane_z), .lane_flat(lane_flat),
    .lane_active(lane_active), .done(done), .exec_mask(exec_mask),
    .grp_x(grp_x), .grp_y(grp_y), .grp_z(grp_z),
    .waves_needed(waves_needed), .fits(fits)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic int exp_mask(input int v);
    int m = 0;
    int tot = VEC[v][0] * VEC[v][1] * VEC[v][2];
    for (int k = 0; k < LANES; k++)
      if (VEC[v][3] * LANES + k < tot) m |= (1 << k);
    return m;
  endfunction

  task automatic check_results(input int v, input string req);
    int tot = VEC[v][0] * VEC[v][1] * VEC[v][2];
    int cx = VEC[v][5];
    int cy = VEC[v][6];
    int g  = VEC[v][4];
    int wv = (tot + LANES - 1) / LANES;
    chk(int'(exec_mask) == exp_mask(v), req, "R6 exec_mask", exec_mask, exp_mask(v));
    chk(int'(grp_x) == g % cx, req, "R7 grp_x", grp_x, g % cx);
    chk(int'(grp_y) == (g / cx) % cy, req, "R7 grp_y", grp_y, (g / cx) % cy);
    chk(int'(grp_z) == g / (cx * cy), req, "R7 grp_z", grp_z, g / (cx * cy));
    chk(int'(waves_needed) == wv, req, "R8 waves_needed", waves_needed, wv);
    chk(fits == (wv <= VEC[v][7]), req, "R8 fits", fits, (wv <= VEC[v][7]));
  endtask

  task automatic launch(input int v);
    size_x     = DIM_W'(VEC[v][0]);
    size_y     = DIM_W'(VEC[v][1]);
    size_z     = DIM_W'(VEC[v][2]);
    wave_idx   = WAVE_W'(VEC[v][3]);
    grp_num    = GRP_W'(VEC[v][4]);
    grid_x     = GRP_W'(VEC[v][5]);
    grid_y     = GRP_W'(VEC[v][6]);
    free_slots = WAVE_W'(VEC[v][7]);
    start      = 1'b1;
  endtask

  task automatic run_vec(input int v, input bit noise, input bit stall);
    int beats = 0;
    bit stalled = 1'b0;
    int sx = VEC[v][0];
    int sy = VEC[v][1];
    int tot = VEC[v][0] * VEC[v][1] * VEC[v][2];
    @(negedge clk);
    launch(v);
    lane_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    if (noise) begin
      repeat (3) @(negedge clk);
      size_x = 8'd9; size_y = 8'd9; size_z = 8'd9;
      wave_idx = 8'd1; grp_num = 16'd77; grid_x = 16'd5; grid_y = 16'd5;
      free_slots = 8'd99; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (beats < LANES) begin
      @(negedge clk);
      cyc++;
      if (lane_valid) begin
        if (stall && !stalled) begin
          stalled = 1'b1;
          lane_ready = 1'b0;
          for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(lane_valid && lane_idx == 0 && int'(lane_x) == (VEC[v][3] * LANES) % sx,
                "R3", "stalled record held", lane_idx, 0);
          end
        end
        lane_ready = ((v % 2) == 0) || (((cyc + v) % 3) != 0);
        if (lane_ready) begin
          int g = VEC[v][3] * LANES + beats;
          chk(int'(lane_idx) == beats, "R3", "lane_idx order", lane_idx, beats);
          chk(int'(lane_x) == g % sx && int'(lane_y) == (g / sx) % sy,
              "R4", "lane_x/lane_y", {lane_x, lane_y},
              ((g % sx) << DIM_W) | ((g / sx) % sy));
          chk(int'(lane_z) == g / (sx * sy), "R4", "lane_z", lane_z, g / (sx * sy));
          chk(int'(lane_flat) == g, "R5", "lane_flat", lane_flat, g);
          chk(lane_active == (g < tot), "R6", "lane_active", lane_active, (g < tot));
          beats++;
        end
      end else begin
        lane_ready = 1'b0;
      end
    end
    @(negedge clk);
    lane_ready = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R9", "done pulse after last lane", done, 1);
    check_results(v, noise ? "R2" : "R9");
    @(negedge clk);
    chk(done == 1'b0, "R9", "done lasts one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && lane_valid == 0 && done == 0, "R1", "control at reset",
        {busy, lane_valid, done}, 0);
    chk(exec_mask == 0 && waves_needed == 0 && fits == 0, "R1", "results at reset",
        exec_mask, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) run_vec(v, 1'b0, 1'b0);

    // R2: stray start while busy is ignored
    run_vec(0, 1'b1, 1'b0);
    // R3: long back-pressure stall on the first record
    run_vec(1, 1'b0, 1'b1);

    // R9: results held while idle even when inputs move
    size_x = 8'd2; grp_num = 16'd123; grid_x = 16'd9; free_slots = 8'd0;
    repeat (6) @(negedge clk);
    check_results(1, "R9");

    // R1: reset in the middle of a launch
    @(negedge clk);
    launch(2);
    @(negedge clk);
    start = 1'b0;
    while (!lane_valid) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 0 && lane_valid == 0 && done == 0 && exec_mask == 0, "R1",
        "mid-launch reset", {busy, lane_valid, done}, 0);
    rst_n = 1'b1;
    run_vec(5, 1'b0, 1'b0);

    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      report();
      $finish;
    end
  end
endmodule